// File: doc/BRIEF.md
# Reset Cause Logging Register

This block keeps a 32-bit record of which chip-wide resets have happened since power was applied. One input is the power-on (cold) reset. Four level inputs are warm reset requests: debug, external pin, watchdog and software. When one of these warm requests drops back to inactive, the block sets a sticky flag for that source. Warm resets never touch the record. Only the cold reset reinitialises it, and it does so with the power-on flag set.

Software reads the record and clears flags over a single-cycle register bus. The bus has an address, a write strobe, write data and combinational read data. A flag is cleared by writing 1 to its bit. Boot code uses the record to find out why the chip restarted.

Top module: `rst_cause_log`

## Requirements
- R1: The record sits at byte offset 0x8 (parameter `REG_OFF`). Its flag bits are: bit 0 power-on, bit 1 software warm, bit 4 watchdog warm, bit 5 external warm, bit 9 debug warm. `warm_req[0]` is debug, `[1]` external, `[2]` watchdog and `[3]` software.
- R2: A warm flag is set on the first rising clock edge at which its request is seen low after having been high. While the request stays high, the flag is not set.
- R3: A set flag stays set while any warm request is asserted or released. Writing 0 to a flag bit leaves it unchanged.
- R4: While `por_n` is low, and right after it rises, the record reads 0x0000_0001.
- R5: Bits 31..10, 8..6 and 3 always read 0. Writes to them have no effect.
- R6: Bit 2 is a plain read/write bit. It is 0 after cold reset and takes `wdata[2]` on every write to the record.
- R7: If a release and a write of 1 to the same flag bit fall on the same edge, the flag ends up set.
- R8: Warm requests released on the same edge each set their own flag and no other.
- R9: Reads at any address other than `REG_OFF` return 0. Writes there change nothing.
- R10: Writing 1 to bit 0 clears the power-on flag. No warm request sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| warm_req | input | 4 | Warm reset request levels, active high (debug, external, watchdog, software) |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |

## Verification
The bench builds the block with its defaults: an 8-bit address and offset 0x8. With these settings every bus address can be read and every one of the 16 release patterns of the four warm requests can be swept. Expected record values are assembled arithmetically from the bit positions in R1. Each release pattern is checked while the requests are still held and again after they drop. The bench also covers a set and a clear landing on the same edge, writes to reserved bits and to foreign addresses, and a second cold reset after flags have built up.

// File: rtl/rst_cause_log.sv
module rst_cause_log #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned REG_OFF = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [3:0]        warm_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int unsigned NSRC = 4;
  localparam int unsigned FPOS [0:NSRC-1] = '{9, 5, 4, 1};
  localparam logic [31:0] RSV_MASK = 32'hFFFF_FDC8;

  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] rel;
  logic            cold_q;
  logic            spare_q;
  logic            hit;
  logic            wr_hit;
  logic [31:0]     word;

  assign hit    = (bus_addr == ADDR_W'(REG_OFF));
  assign wr_hit = hit && bus_we;
  assign rel    = req_q & ~warm_req;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) req_q <= '0;
    else        req_q <= warm_req;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge por_n)
      if (!por_n)                              flag_q[i] <= 1'b0;
      else if (rel[i])                         flag_q[i] <= 1'b1;
      else if (wr_hit && bus_wdata[FPOS[i]])   flag_q[i] <= 1'b0;

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      rel[i] |=> bus_rdata[FPOS[i]] || !hit);
    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      flag_q[i] && !(wr_hit && bus_wdata[FPOS[i]]) |=> flag_q[i]);
    // R8
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      !flag_q[i] && !rel[i] |=> !flag_q[i]);
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                        cold_q <= 1'b1;
    else if (wr_hit && bus_wdata[0])   cold_q <= 1'b0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      spare_q <= 1'b0;
    else if (wr_hit) spare_q <= bus_wdata[2];

  assign word = {22'b0, flag_q[0], 3'b0, flag_q[1], flag_q[2], 1'b0,
                 spare_q, flag_q[3], cold_q};
  assign bus_rdata = hit ? word : 32'b0;

  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rdata & RSV_MASK) == 32'b0);
  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    !hit |-> bus_rdata == 32'b0);
  // R10
  cold_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !cold_q |=> !cold_q);

endmodule

// File: tb/test_rst_cause_log.sv
module test_rst_cause_log;
  localparam int unsigned OFF = 8;

  logic        clk = 0;
  logic        por_n = 0;
  logic [3:0]  warm_req = '0;
  logic [7:0]  bus_addr = 8'(OFF);
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int total = 0, bad = 0;

  rst_cause_log i_rst_cause_log (
    .clk(clk), .por_n(por_n), .warm_req(warm_req), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  function automatic logic [31:0] pos_of(logic [3:0] m);
    return (32'(m[0]) << 9) | (32'(m[1]) << 5) | (32'(m[2]) << 4) | (32'(m[3]) << 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic rd_check(string req, logic [31:0] exp);
    bus_addr = 8'(OFF);
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 8'(OFF); bus_wdata = '0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=%08h exp=%08h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_check("R4 during cold reset", 32'h1);
    por_n = 1;
    @(negedge clk);
    rd_check("R4 after cold reset", 32'h1);

    for (int a = 0; a < 256; a++) begin
      bus_addr = 8'(a);
      #1 if (a != OFF) check("R9 read other addr", bus_rdata, 32'h0);
    end
    bus_addr = 8'(OFF);

    wr(8'(OFF), 32'h0);
    rd_check("R3 write zero keeps cold flag", 32'h1);
    wr(8'(OFF), 32'h1);
    rd_check("R10 clear cold flag", 32'h0);

    for (int m = 0; m < 16; m++) begin
      @(negedge clk); warm_req = 4'(m);
      repeat (2) @(negedge clk);
      rd_check("R2 no set while active", 32'h0);
      warm_req = '0;
      @(negedge clk);
      rd_check("R8 release pattern", pos_of(4'(m)));
      warm_req = 4'hF;
      repeat (2) @(negedge clk);
      warm_req = '0;
      @(negedge clk);
      rd_check("R1 all warm flags", 32'h232);
      wr(8'(OFF), 32'h0);
      rd_check("R3 write zero keeps flags", 32'h232);
      wr(8'(OFF), pos_of(4'(m)));
      rd_check("R3 partial clear", 32'h232 & ~pos_of(4'(m)));
      wr(8'(OFF), 32'h232);
      rd_check("R10 cold flag stays clear", 32'h0);
    end

    @(negedge clk); warm_req = 4'b0001;
    @(negedge clk);
    warm_req = '0; bus_we = 1; bus_wdata = 32'h200;
    @(negedge clk); bus_we = 0; bus_wdata = '0;
    rd_check("R7 set wins over clear", 32'h200);

    wr(8'(OFF), 32'hFFFF_FDCC);
    rd_check("R5 reserved write ignored, R6 spare set", 32'h204);
    wr(8'(OFF), 32'h0);
    rd_check("R6 spare follows write", 32'h200);
    wr(8'(OFF+4), 32'hFFFF_FFFF);
    rd_check("R9 foreign write ignored", 32'h200);

    @(negedge clk); warm_req = 4'b1000;
    @(negedge clk); por_n = 0;
    #1 check("R4 cold reset reinit", bus_rdata, 32'h1);
    @(negedge clk); warm_req = '0; por_n = 1;
    @(negedge clk);
    rd_check("R4 no stale release after cold reset", 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule